// File: doc/BRIEF.md
# Segment Address Translator

This block turns a two-part virtual address, a segment number plus a byte displacement, into a physical address. A small fully associative buffer keeps the descriptors of recently used segments. Each descriptor holds the segment number, the segment's physical base and its length. On a buffer hit the displacement is compared against the length and added to the base within the cycle of acceptance. The result is registered and appears one cycle later.

On a miss, the block stops accepting requests and reads the segment's descriptor from an in-memory table. The table starts at a programmable base and has one entry every `1 << ENTRY_SHIFT` bytes. When the descriptor arrives, the block fills a buffer slot and completes the translation. A descriptor whose present flag is clear raises a missing-segment fault and is not kept. A segment number beyond the programmable table length is rejected without any table read. A flush input empties the whole buffer in one cycle.

Top module: `seg_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `mem_req_valid` are 0, and the buffer holds no valid descriptor, so the first lookup of any segment misses.
- R2: A request accepted (`req_valid` and `req_ready` both high at a clock edge) whose segment is in the buffer produces `rsp_valid` in the next cycle with `rsp_paddr = base + displacement`, `rsp_fault = 0`, and no table read.
- R3: A displacement greater than or equal to the segment length yields `rsp_fault = 1` and `rsp_paddr = 0`. This applies on the hit path and on the refill path.
- R4: On a miss, `mem_req_valid` rises in the cycle after acceptance with `mem_req_addr = tbl_base + (seg << ENTRY_SHIFT)`. Both hold, and `req_ready` stays 0, until the cycle in which `mem_rsp_valid` is seen. The translation result appears in the following cycle.
- R5: `mem_rsp_data` is laid out as {present (MSB), base (PA_W bits), length (DISP_W bits, LSBs)}. A descriptor with present = 0 gives `rsp_fault = 2`, `rsp_paddr = 0` and no fill, so a later access to that segment misses again.
- R6: A segment number with `seg >= tbl_len` gives `rsp_fault = 3` in the next cycle with no table read. This check takes priority over a buffer hit.
- R7: After a present descriptor is fetched it is kept, even if its own translation faulted on length, and the next access to that segment hits.
- R8: Fills take buffer slots in round-robin order starting at slot 0. With ENTRIES slots, the (ENTRIES+1)-th fill evicts the segment from the first fill and no other.
- R9: `flush` high at a clock edge invalidates all entries. A request accepted in that same cycle is treated as a miss. A fill completing in that same cycle is still kept.
- R10: Each accepted request produces exactly one `rsp_valid` pulse of one cycle. `rsp_valid` and `mem_req_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_seg | input | SEG_W | Segment number |
| req_disp | input | DISP_W | Displacement within the segment |
| tbl_base | input | PA_W | Physical address of the segment table |
| tbl_len | input | SEG_W+1 | Number of valid segment table entries |
| flush | input | 1 | Invalidate all buffered descriptors |
| rsp_valid | output | 1 | Result valid (one-cycle pulse) |
| rsp_paddr | output | PA_W | Physical address, 0 on a fault |
| rsp_fault | output | 2 | 0 ok, 1 length exceeded, 2 segment missing, 3 segment number invalid |
| mem_req_valid | output | 1 | Descriptor read pending |
| mem_req_addr | output | PA_W | Descriptor address |
| mem_rsp_valid | input | 1 | Descriptor returned |
| mem_rsp_data | input | 1+PA_W+DISP_W | Descriptor {present, base, length} |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a flush and a lookup. The bench raises `flush` together with a request for a segment it knows is buffered and expects a table read at the right address. It also raises `flush` in the cycle the descriptor returns and then expects a hit on that segment while other segments miss. The second pair is the table-length check and a buffer hit. The bench shrinks `tbl_len` below a segment that is already buffered and expects fault 3 with `mem_req_valid` staying low.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int SEG_W       = 6,
  parameter int DISP_W      = 12,
  parameter int PA_W        = 20,
  parameter int ENTRIES     = 8,
  parameter int ENTRY_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic [DISP_W-1:0] req_disp,
  input  logic [PA_W-1:0]   tbl_base,
  input  logic [SEG_W:0]    tbl_len,
  input  logic              flush,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [1:0]        rsp_fault,
  output logic              mem_req_valid,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [PA_W+DISP_W:0] mem_rsp_data
);
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int DESC_W = 1 + PA_W + DISP_W;
  localparam logic [1:0] F_OK = 2'd0, F_LEN = 2'd1, F_MISS = 2'd2, F_INV = 2'd3;

  typedef enum logic {S_IDLE, S_WAIT} st_t;
  st_t st;

  logic [ENTRIES-1:0] vld;
  logic [SEG_W-1:0]   tag_q  [ENTRIES];
  logic [PA_W-1:0]    base_q [ENTRIES];
  logic [DISP_W-1:0]  lim_q  [ENTRIES];
  logic [IDX_W-1:0]   rr;
  logic [SEG_W-1:0]   seg_q;
  logic [DISP_W-1:0]  disp_q;

  logic              hit;
  logic [PA_W-1:0]   hit_base;
  logic [DISP_W-1:0] hit_lim;

  assign req_ready = (st == S_IDLE);

  wire accept  = req_valid && req_ready;
  wire seg_bad = {1'b0, req_seg} >= tbl_len;
  wire fill    = (st == S_WAIT) && mem_rsp_valid;

  wire              d_present = mem_rsp_data[DESC_W-1];
  wire [PA_W-1:0]   d_base    = mem_rsp_data[DESC_W-2:DISP_W];
  wire [DISP_W-1:0] d_lim     = mem_rsp_data[DISP_W-1:0];

  always_comb begin
    hit      = 1'b0;
    hit_base = '0;
    hit_lim  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (vld[i] && tag_q[i] == req_seg && !flush) begin
        hit      = 1'b1;
        hit_base = hit_base | base_q[i];
        hit_lim  = hit_lim | lim_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st            <= S_IDLE;
      vld           <= '0;
      rr            <= '0;
      seg_q         <= '0;
      disp_q        <= '0;
      rsp_valid     <= 1'b0;
      rsp_paddr     <= '0;
      rsp_fault     <= F_OK;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (flush) vld <= '0;
      case (st)
        S_IDLE: begin
          if (accept) begin
            if (seg_bad) begin
              rsp_valid <= 1'b1;
              rsp_fault <= F_INV;
              rsp_paddr <= '0;
            end else if (hit) begin
              rsp_valid <= 1'b1;
              if (req_disp >= hit_lim) begin
                rsp_fault <= F_LEN;
                rsp_paddr <= '0;
              end else begin
                rsp_fault <= F_OK;
                rsp_paddr <= hit_base + PA_W'(req_disp);
              end
            end else begin
              st            <= S_WAIT;
              seg_q         <= req_seg;
              disp_q        <= req_disp;
              mem_req_valid <= 1'b1;
              mem_req_addr  <= tbl_base + (PA_W'(req_seg) << ENTRY_SHIFT);
            end
          end
        end
        S_WAIT: begin
          if (mem_rsp_valid) begin
            st            <= S_IDLE;
            mem_req_valid <= 1'b0;
            rsp_valid     <= 1'b1;
            if (!d_present) begin
              rsp_fault <= F_MISS;
              rsp_paddr <= '0;
            end else begin
              vld[rr] <= 1'b1;
              rr      <= (rr == IDX_W'(ENTRIES-1)) ? '0 : rr + 1'b1;
              if (disp_q >= d_lim) begin
                rsp_fault <= F_LEN;
                rsp_paddr <= '0;
              end else begin
                rsp_fault <= F_OK;
                rsp_paddr <= d_base + PA_W'(disp_q);
              end
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (fill && d_present) begin
      tag_q[rr]  <= seg_q;
      base_q[rr] <= d_base;
      lim_q[rr]  <= d_lim;
    end
  end

  // R2
  hit_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !seg_bad && hit) |=> (rsp_valid && !mem_req_valid));

  // R6
  bad_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && ({1'b0, req_seg} >= tbl_len)) |=>
      (rsp_valid && rsp_fault == F_INV && !mem_req_valid));

  // R4
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_rsp_valid) |=>
      (mem_req_valid && !req_ready && $stable(mem_req_addr)));

  // R4
  read_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_rsp_valid) |=> (rsp_valid && !mem_req_valid && req_ready));

  // R3
  fault_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != F_OK) |-> (rsp_paddr == '0));

  // R10
  rsp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && mem_req_valid));

  // R9
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !fill) |=> (vld == '0));
endmodule

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb;
  localparam int CLK_P = 10;
  localparam int SEG_W = 6, DISP_W = 12, PA_W = 20, ENTRIES = 8, ENTRY_SHIFT = 3;
  localparam int NV = 25;
  localparam logic [PA_W-1:0] TBASE = 20'h40000;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, flush = 0, mem_rsp_valid = 0;
  logic [SEG_W-1:0] req_seg = '0;
  logic [DISP_W-1:0] req_disp = '0;
  logic [PA_W-1:0] tbl_base = TBASE;
  logic [SEG_W:0] tbl_len = 7'd40;
  logic [PA_W+DISP_W:0] mem_rsp_data = '0;
  logic req_ready, rsp_valid, mem_req_valid;
  logic [PA_W-1:0] rsp_paddr, mem_req_addr;
  logic [1:0] rsp_fault;

  int errors = 0, checks = 0, mem_lat = 1;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  seg_xlate #(.SEG_W(SEG_W), .DISP_W(DISP_W), .PA_W(PA_W), .ENTRIES(ENTRIES),
              .ENTRY_SHIFT(ENTRY_SHIFT)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_seg(req_seg), .req_disp(req_disp), .tbl_base(tbl_base), .tbl_len(tbl_len),
    .flush(flush), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data));

  // stimulus rows: {seg, disp, flush with request, expected miss}
  localparam logic [19:0] VECS [NV] = '{
    {6'd1,  12'h010, 1'b0, 1'b1}, {6'd1,  12'h020, 1'b0, 1'b0},
    {6'd1,  12'h110, 1'b0, 1'b0}, {6'd1,  12'h10F, 1'b0, 1'b0},
    {6'd2,  12'h005, 1'b0, 1'b1}, {6'd45, 12'h000, 1'b0, 1'b0},
    {6'd6,  12'h000, 1'b0, 1'b1}, {6'd6,  12'h000, 1'b0, 1'b1},
    {6'd3,  12'h200, 1'b0, 1'b1}, {6'd3,  12'h030, 1'b0, 1'b0},
    {6'd4,  12'h001, 1'b0, 1'b1}, {6'd5,  12'h002, 1'b0, 1'b1},
    {6'd7,  12'h003, 1'b0, 1'b1}, {6'd8,  12'h004, 1'b0, 1'b1},
    {6'd9,  12'h005, 1'b0, 1'b1}, {6'd10, 12'h006, 1'b0, 1'b1},
    {6'd2,  12'h007, 1'b0, 1'b0}, {6'd1,  12'h008, 1'b0, 1'b1},
    {6'd2,  12'h009, 1'b0, 1'b1}, {6'd4,  12'h00A, 1'b0, 1'b0},
    {6'd4,  12'h000, 1'b1, 1'b1}, {6'd5,  12'h00B, 1'b0, 1'b1},
    {6'd4,  12'h00C, 1'b0, 1'b0}, {6'd39, 12'h000, 1'b0, 1'b1},
    {6'd40, 12'h000, 1'b0, 1'b0}
  };

  function automatic logic [PA_W+DISP_W:0] desc(input int s);
    logic [PA_W-1:0] b = PA_W'(s * 32'h400 + 32'h100);
    logic [DISP_W-1:0] l = DISP_W'(32'h100 + s * 16);
    return {((s % 7) != 6), b, l};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic xlate(input int s, input int d, input bit fl, input bit exp_miss, input bit fill_fl);
    logic [PA_W+DISP_W:0] de = desc(s);
    int ef, ep;
    string tg;
    if (s >= int'(tbl_len)) begin ef = 3; ep = 0; end
    else if (!de[PA_W+DISP_W]) begin ef = 2; ep = 0; end
    else if (d >= int'(de[DISP_W-1:0])) begin ef = 1; ep = 0; end
    else begin ef = 0; ep = int'(de[PA_W+DISP_W-1:DISP_W]) + d; end
    tg = (ef == 3) ? "R6" : (ef == 2) ? "R5" : (ef == 1) ? "R3" : (exp_miss ? "R4" : "R2");
    req_valid = 1; req_seg = SEG_W'(s); req_disp = DISP_W'(d); flush = fl;
    @(posedge clk); @(negedge clk);
    req_valid = 0; flush = 0;
    chk(mem_req_valid == exp_miss, fl ? "R9" : "R7/R8", "table read issued", mem_req_valid, exp_miss);
    if (mem_req_valid) begin
      chk(mem_req_addr == TBASE + PA_W'(s << ENTRY_SHIFT), "R4", "descriptor addr",
          mem_req_addr, TBASE + PA_W'(s << ENTRY_SHIFT));
      chk(!req_ready && !rsp_valid, "R4", "stall while reading", {req_ready, rsp_valid}, 0);
      for (int k = 1; k < mem_lat; k++) begin
        @(negedge clk);
        chk(mem_req_valid && !req_ready, "R4", "read held", {mem_req_valid, req_ready}, 2);
      end
      mem_rsp_valid = 1; mem_rsp_data = de; flush = fill_fl;
      @(posedge clk); @(negedge clk);
      mem_rsp_valid = 0; flush = 0;
    end
    chk(rsp_valid == 1, tg, "rsp_valid", rsp_valid, 1);
    chk(int'(rsp_fault) == ef, tg, "fault", rsp_fault, ef);
    chk(int'(rsp_paddr) == ep, tg, "paddr", rsp_paddr, ep);
    @(negedge clk);
    chk(!rsp_valid, "R10", "single pulse", rsp_valid, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(req_ready && !rsp_valid && !mem_req_valid, "R1", "reset outputs",
        {req_ready, rsp_valid, mem_req_valid}, 4);
    for (int i = 0; i < NV; i++) begin
      mem_lat = (i % 3) + 1;
      xlate(int'(VECS[i][19:14]), int'(VECS[i][13:2]), VECS[i][1], VECS[i][0], 1'b0);
    end
    // R6: priority over a buffered segment (seg 4 sits in the buffer)
    tbl_len = 7'd4;
    xlate(4, 0, 1'b0, 1'b0, 1'b0);
    tbl_len = 7'd40;
    xlate(4, 1, 1'b0, 1'b0, 1'b0);
    // R9: flush in the cycle the descriptor returns keeps that fill only
    mem_lat = 2;
    xlate(11, 3, 1'b0, 1'b1, 1'b1);
    xlate(11, 4, 1'b0, 1'b0, 1'b0);
    xlate(5, 5, 1'b0, 1'b1, 1'b0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule